// File: doc/BRIEF.md
# Power-Good Strap Latch with Test Override

This block records the board's frequency-select straps a single time during power-up. Three strap pins choose the host clock frequency. The block takes their value on the first cycle in which the power-good input is seen high after reset. From then on the captured code is held, and the decoded host frequency in MHz is reported together with a valid flag. Code 111 is reported as reserved.

A test-select input overrides the one-shot behaviour. While test-select is high, the captured code and the valid flag follow the pins and power-good on every cycle. A test-control input then chooses one of two output behaviours: tri-stated outputs or a divided reference. When test mode ends, the captured code and the valid flag keep their last values.

The block is used next to the clock synthesizer, which reads the held code and the test controls. All inputs are asynchronous to the clock, so each one passes through a synchronizer before it is used.

Top module: `strap_latch`

## Requirements
- R1: After asynchronous reset, `valid_o`, `strap_o` (000), `freq_mhz_o` (0), `reserved_o`, `test_mode_o`, `tristate_o` and `refdiv_o` are all low.
- R2: On the first synchronized cycle with `pwr_good_i` high, while not in test mode, `strap_o` takes the pins. The bit order is {C,B,A} = {`strap_i[2]`,`strap_i[1]`,`strap_i[0]`}. `valid_o` goes high at the same time.
- R3: Once `valid_o` is high outside test mode, later changes on `strap_i` and on `pwr_good_i` leave `strap_o` and `valid_o` unchanged.
- R4: While valid, `freq_mhz_o` decodes `strap_o` as follows: 000=266, 001=133, 010=200, 011=166, 100=333, 101=100, 110=400.
- R5: While valid with `strap_o`=111, `reserved_o` is 1 and `freq_mhz_o` is 0. For any other code, `reserved_o` is 0.
- R6: Before any capture, `valid_o` is 0, `freq_mhz_o` is 0 and `strap_o` stays 000, whatever the strap pins do.
- R7: While `test_sel_i` is high, `test_mode_o` is 1. Every cycle, `strap_o` follows the synchronized pins and `valid_o` follows the synchronized `pwr_good_i`.
- R8: In test mode, `test_ctl_i`=0 drives `tristate_o`=1, and `test_ctl_i`=1 drives `refdiv_o`=1. Outside test mode, both outputs are 0.
- R9: A change on any input reaches the registered outputs on the third rising clock edge after it is applied. Two of these edges are synchronizer stages, and the third is the output register.
- R10: After test mode ends, `strap_o` and `valid_o` keep the values they had in test mode. If `valid_o` was high, later pin changes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwr_good_i | input | 1 | Power-good input, asynchronous |
| strap_i | input | 3 | Frequency-select straps {C,B,A}, asynchronous |
| test_sel_i | input | 1 | Test-mode select, high enters test mode |
| test_ctl_i | input | 1 | Test behaviour: 0 tri-state, 1 divided reference |
| strap_o | output | 3 | Captured strap code |
| valid_o | output | 1 | Strap code has been captured |
| freq_mhz_o | output | 9 | Decoded host frequency in MHz, 0 when invalid or reserved |
| reserved_o | output | 1 | Captured code is the reserved value 111 |
| test_mode_o | output | 1 | Test mode active |
| tristate_o | output | 1 | Test mode requests tri-stated outputs |
| refdiv_o | output | 1 | Test mode requests divided reference output |

## Verification
All registered outputs are due on the third rising edge after an input is driven. The decoded frequency and the reserved flag are combinational from those registers, so they are due on the same edge. The bench drives inputs on the falling edge, waits three rising edges and samples one time unit later. In the latency test it also samples after only two edges, to confirm that the output has not moved early. The one-shot hold is checked by waiting the full three edges after each disturbing pin change, so that an update, if the design made one, would already be visible.

// File: rtl/strap_latch_pkg.sv
package strap_latch_pkg;
  localparam int STRAP_W = 3;
  localparam int FREQ_W  = 9;
  localparam logic [STRAP_W-1:0] RESERVED_CODE = '1;

  function automatic logic [FREQ_W-1:0] freq_of_code(input logic [STRAP_W-1:0] code);
    logic [FREQ_W-1:0] mhz;
    case (code)
      3'd0:    mhz = FREQ_W'(266);
      3'd1:    mhz = FREQ_W'(133);
      3'd2:    mhz = FREQ_W'(200);
      3'd3:    mhz = FREQ_W'(166);
      3'd4:    mhz = FREQ_W'(333);
      3'd5:    mhz = FREQ_W'(100);
      3'd6:    mhz = FREQ_W'(400);
      default: mhz = '0;
    endcase
    return mhz;
  endfunction

  function automatic logic is_reserved(input logic [STRAP_W-1:0] code);
    return code == RESERVED_CODE;
  endfunction
endpackage

// File: rtl/strap_sync.sv
module strap_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [WIDTH-1:0] stage_d;
    if (s == 0) begin : g_first
      assign stage_d = d_i;
    end else begin : g_next
      assign stage_d = stage_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_d;
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/strap_capture.sv
module strap_capture
  import strap_latch_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pg_s,
  input  logic [STRAP_W-1:0] strap_s,
  input  logic               tsel_s,
  input  logic               tctl_s,
  output logic [STRAP_W-1:0] strap_q,
  output logic               valid_q,
  output logic               tmode_q,
  output logic               tri_q,
  output logic               refdiv_q,
  output logic               cap_fire
);
  logic load_en;

  // one-shot capture: first synchronized power-good outside test mode
  assign cap_fire = pg_s && !valid_q && !tsel_s;
  assign load_en  = cap_fire || tsel_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strap_q  <= '0;
      valid_q  <= 1'b0;
      tmode_q  <= 1'b0;
      tri_q    <= 1'b0;
      refdiv_q <= 1'b0;
    end else begin
      if (load_en) strap_q <= strap_s;
      if (tsel_s)  valid_q <= pg_s;
      else if (cap_fire) valid_q <= 1'b1;
      tmode_q  <= tsel_s;
      tri_q    <= tsel_s && !tctl_s;
      refdiv_q <= tsel_s && tctl_s;
    end
  end
endmodule

// File: rtl/strap_decode.sv
module strap_decode
  import strap_latch_pkg::*;
(
  input  logic [STRAP_W-1:0] code_i,
  input  logic               valid_i,
  output logic [FREQ_W-1:0]  mhz_o,
  output logic               reserved_o
);
  assign mhz_o      = valid_i ? freq_of_code(code_i) : '0;
  assign reserved_o = valid_i && is_reserved(code_i);
endmodule

// File: rtl/strap_latch.sv
module strap_latch
  import strap_latch_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pwr_good_i,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic               test_sel_i,
  input  logic               test_ctl_i,
  output logic [STRAP_W-1:0] strap_o,
  output logic               valid_o,
  output logic [FREQ_W-1:0]  freq_mhz_o,
  output logic               reserved_o,
  output logic               test_mode_o,
  output logic               tristate_o,
  output logic               refdiv_o
);
  localparam int SYNC_W = STRAP_W + 3;

  logic [SYNC_W-1:0]  raw_bus;
  logic [SYNC_W-1:0]  sync_bus;
  logic               pg_s;
  logic               tsel_s;
  logic               tctl_s;
  logic [STRAP_W-1:0] strap_s;
  logic               cap_fire;

  assign raw_bus = {test_ctl_i, test_sel_i, pwr_good_i, strap_i};

  strap_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) i_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (raw_bus),
    .q_o   (sync_bus)
  );

  assign strap_s = sync_bus[STRAP_W-1:0];
  assign pg_s    = sync_bus[STRAP_W];
  assign tsel_s  = sync_bus[STRAP_W+1];
  assign tctl_s  = sync_bus[STRAP_W+2];

  strap_capture i_capture (
    .clk      (clk),
    .rst_n    (rst_n),
    .pg_s     (pg_s),
    .strap_s  (strap_s),
    .tsel_s   (tsel_s),
    .tctl_s   (tctl_s),
    .strap_q  (strap_o),
    .valid_q  (valid_o),
    .tmode_q  (test_mode_o),
    .tri_q    (tristate_o),
    .refdiv_q (refdiv_o),
    .cap_fire (cap_fire)
  );

  strap_decode i_decode (
    .code_i     (strap_o),
    .valid_i    (valid_o),
    .mhz_o      (freq_mhz_o),
    .reserved_o (reserved_o)
  );
endmodule

// File: rtl/strap_latch_chk.sv
module strap_latch_chk
  import strap_latch_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic [STRAP_W-1:0] strap_o,
  input logic               valid_o,
  input logic [FREQ_W-1:0]  freq_mhz_o,
  input logic               reserved_o,
  input logic               test_mode_o,
  input logic               tristate_o,
  input logic               refdiv_o,
  input logic               cap_fire
);
  // R3: held code does not move outside test mode
  p_hold_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(valid_o) && !test_mode_o) |-> $stable(strap_o));

  // R3: valid stays set outside test mode
  p_valid_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(valid_o) && !test_mode_o) |-> valid_o);

  // R2: a capture event makes the code valid on the next edge
  p_capture_sets_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cap_fire |=> valid_o);

  // R6: no frequency reported before capture
  p_freq_zero_invalid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> (freq_mhz_o == '0));

  // R5: reserved flag only for a valid 111
  p_reserved_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
    reserved_o |-> (valid_o && strap_o == RESERVED_CODE && freq_mhz_o == '0));

  // R8: test outputs exclusive and only in test mode
  p_test_out_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({tristate_o, refdiv_o}) <= 1);

  p_test_out_mode_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tristate_o || refdiv_o) |-> test_mode_o);

  // R7: in test mode exactly one test behaviour is requested
  p_test_mode_out_r7: assert property (@(posedge clk) disable iff (!rst_n)
    test_mode_o |-> (tristate_o || refdiv_o));
endmodule

bind strap_latch strap_latch_chk i_strap_latch_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .strap_o     (strap_o),
  .valid_o     (valid_o),
  .freq_mhz_o  (freq_mhz_o),
  .reserved_o  (reserved_o),
  .test_mode_o (test_mode_o),
  .tristate_o  (tristate_o),
  .refdiv_o    (refdiv_o),
  .cap_fire    (cap_fire)
);

// File: tb/test_strap_latch.sv
module test_strap_latch;
  localparam int CLK_PERIOD = 10;
  localparam int LAT = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pwr_good_i = 1'b0;
  logic [2:0] strap_i = 3'b000;
  logic       test_sel_i = 1'b0;
  logic       test_ctl_i = 1'b0;
  logic [2:0] strap_o;
  logic       valid_o;
  logic [8:0] freq_mhz_o;
  logic       reserved_o;
  logic       test_mode_o;
  logic       tristate_o;
  logic       refdiv_o;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  strap_latch i_strap_latch (
    .clk(clk), .rst_n(rst_n), .pwr_good_i(pwr_good_i), .strap_i(strap_i),
    .test_sel_i(test_sel_i), .test_ctl_i(test_ctl_i), .strap_o(strap_o),
    .valid_o(valid_o), .freq_mhz_o(freq_mhz_o), .reserved_o(reserved_o),
    .test_mode_o(test_mode_o), .tristate_o(tristate_o), .refdiv_o(refdiv_o)
  );

  // expected frequencies, indexed by strap code
  function automatic int exp_mhz(input int code);
    int table_mhz [8] = '{266, 133, 200, 166, 333, 100, 400, 0};
    return table_mhz[code];
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic settle(input int edges);
    repeat (edges) @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    pwr_good_i = 1'b0; strap_i = 3'b000; test_sel_i = 1'b0; test_ctl_i = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset_state();
    do_reset();
    #1;
    check("R1 valid", valid_o, 0);
    check("R1 strap", strap_o, 0);
    check("R1 freq", freq_mhz_o, 0);
    check("R1 reserved", reserved_o, 0);
    check("R1 test_mode", test_mode_o, 0);
    check("R1 tristate", tristate_o, 0);
    check("R1 refdiv", refdiv_o, 0);
  endtask

  task automatic t_precapture();
    do_reset();
    for (int c = 1; c < 8; c += 3) begin
      @(negedge clk); strap_i = 3'(c);
      settle(LAT);
      check("R6 valid before pg", valid_o, 0);
      check("R6 freq before pg", freq_mhz_o, 0);
      check("R6 strap before pg", strap_o, 0);
    end
  endtask

  task automatic t_decode_all();
    for (int c = 0; c < 8; c++) begin
      do_reset();
      @(negedge clk); strap_i = 3'(c); pwr_good_i = 1'b1;
      settle(LAT);
      check("R2 strap captured", strap_o, c);
      check("R2 valid", valid_o, 1);
      check("R4 freq decode", freq_mhz_o, exp_mhz(c));
      check("R5 reserved flag", reserved_o, (c == 7) ? 1 : 0);
    end
  endtask

  task automatic t_latency();
    do_reset();
    @(negedge clk); strap_i = 3'b101; pwr_good_i = 1'b1;
    settle(LAT - 1);
    check("R9 not early valid", valid_o, 0);
    settle(1);
    check("R9 on time valid", valid_o, 1);
    check("R9 on time freq", freq_mhz_o, 100);
  endtask

  task automatic t_one_shot();
    do_reset();
    @(negedge clk); strap_i = 3'b011; pwr_good_i = 1'b1;
    settle(LAT);
    @(negedge clk); strap_i = 3'b100;
    settle(LAT);
    check("R3 strap held after pin change", strap_o, 3);
    @(negedge clk); pwr_good_i = 1'b0;
    settle(LAT);
    check("R3 valid held after pg low", valid_o, 1);
    @(negedge clk); strap_i = 3'b110; pwr_good_i = 1'b1;
    settle(LAT);
    check("R3 no recapture on second pg", strap_o, 3);
    check("R3 freq held", freq_mhz_o, 166);
  endtask

  task automatic t_test_mode();
    do_reset();
    @(negedge clk); test_sel_i = 1'b1; test_ctl_i = 1'b0; strap_i = 3'b101; pwr_good_i = 1'b1;
    settle(LAT);
    check("R7 test_mode", test_mode_o, 1);
    check("R7 strap live", strap_o, 5);
    check("R7 valid follows pg", valid_o, 1);
    check("R8 tristate", tristate_o, 1);
    check("R8 refdiv off", refdiv_o, 0);
    @(negedge clk); strap_i = 3'b010;
    settle(LAT);
    check("R7 strap follows change", strap_o, 2);
    check("R7 freq follows change", freq_mhz_o, 200);
    @(negedge clk); pwr_good_i = 1'b0; test_ctl_i = 1'b1;
    settle(LAT);
    check("R7 valid drops with pg", valid_o, 0);
    check("R8 refdiv", refdiv_o, 1);
    check("R8 tristate off", tristate_o, 0);
    @(negedge clk); pwr_good_i = 1'b1; strap_i = 3'b110;
    settle(LAT);
    @(negedge clk); test_sel_i = 1'b0;
    settle(LAT);
    check("R10 test_mode off", test_mode_o, 0);
    check("R8 outputs off outside test", tristate_o + refdiv_o, 0);
    check("R10 strap kept", strap_o, 6);
    check("R10 valid kept", valid_o, 1);
    @(negedge clk); strap_i = 3'b001;
    settle(LAT);
    check("R10 later pins ignored", strap_o, 6);
    check("R10 freq kept", freq_mhz_o, 400);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset_state();
    t_precapture();
    t_decode_all();
    t_latency();
    t_one_shot();
    t_test_mode();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule